// File: doc/BRIEF.md
# Three-Stage Handshaked Pipeline Controller

This block sequences work items through three processing stages that each take a number of cycles that depends on the data. Each stage is run by its own small state machine. Neighbouring stages talk over a four-phase request/acknowledge link. A stage that finishes raises a request toward the next stage. It holds the request until the next stage acknowledges, and only then returns to take new work from the stage before it. Because of this, stages overlap: while one item is processed downstream, the next item is already being processed upstream.

The datapaths are not part of the block. Each stage has a one-cycle `start` strobe and a tag bus toward its datapath, and a `done` pulse back from it. A small tag travels with every item and is latched on each acknowledge, so the order of items can be seen at every stage. The source uses the same four-phase link as the internal stages, and so does the sink.

Top module: `pipe3_hs`

## Requirements
- R1: While reset is high, and on the first cycle after it, `inAck`, `outValid` and every `stageStart` bit are 0, and no stage holds an item.
- R2: An idle stage that sees its upstream request high raises its acknowledge on the next cycle. It captures the upstream tag on that same edge and keeps the acknowledge high until the request goes low.
- R3: A request on any link, `outValid` included, stays high with a stable tag until the acknowledge rises.
- R4: A stage gives exactly one single-cycle `stageStart` pulse for each item it accepts. The pulse comes in the cycle in which the upstream request is seen low while the acknowledge is still high. During the pulse the stage's tag field equals the accepted item's tag. Stage k's field is bits k*TAG_W+TAG_W-1 down to k*TAG_W of `stageTag`.
- R5: A stage offers an item downstream only after its `stageDone` has been seen high while the stage was busy. A `stageDone` pulse on a stage that is not busy is ignored.
- R6: A stage accepts no new item while it still holds an item that has not been handed downstream, so a full pipeline leaves `inAck` low.
- R7: Items leave at `outTag` in the order they entered, each exactly once.
- R8: Stages work concurrently. Two items sent back to back finish in less than 1.75 times the latency of one item sent alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Source request, four-phase |
| inTag | input | TAG_W | Tag of the offered item |
| inAck | output | 1 | Acknowledge to the source |
| stageStart | output | STAGES | One-cycle start strobe per stage datapath |
| stageTag | output | STAGES*TAG_W | Tag held by each stage, stage k at bits k*TAG_W upward |
| stageDone | input | STAGES | Completion pulse from each stage datapath |
| outValid | output | 1 | Request toward the sink, four-phase |
| outTag | output | TAG_W | Tag of the delivered item |
| outAck | input | 1 | Acknowledge from the sink |

## Verification
On every cycle the assertions check the local link rules. Requests hold until acknowledged, acknowledges hold while the request is high, and start pulses last one cycle. An offer never rises without a prior done, and reset clears the handshake lines. Only the bench scenarios can show the properties that span the whole pipeline. These are in-order delivery without loss or duplication under random stage latencies and sink stalls, the blocking of the input when the pipeline is full, stray done pulses having no effect, and the throughput gain from stage overlap.

// File: rtl/pipe3_pkg.sv
package pipe3_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACK,
    ST_BUSY,
    ST_OFFER,
    ST_RELEASE
  } stageState_e;

  typedef struct packed {
    logic latch;
    logic start;
  } stageStrobe_t;

endpackage

// File: rtl/pipe_stage_fsm.sv
module pipe_stage_fsm
  import pipe3_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         upReq,
  output logic         upAck,
  output logic         dnReq,
  input  logic         dnAck,
  input  logic         stDone,
  output stageStrobe_t strobe
);

  stageState_e state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      ST_IDLE:    if (upReq) begin nextState = ST_ACK; strobe.latch = 1'b1; end
      ST_ACK:     if (!upReq) begin nextState = ST_BUSY; strobe.start = 1'b1; end
      ST_BUSY:    if (stDone) nextState = ST_OFFER;
      ST_OFFER:   if (dnAck) nextState = ST_RELEASE;
      ST_RELEASE: if (!dnAck) nextState = ST_IDLE;
      default:    nextState = ST_IDLE;
    endcase
  end

  assign upAck = (state == ST_ACK);
  assign dnReq = (state == ST_OFFER);

  // R1
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!upAck && !dnReq && !strobe.start));

  // R2
  assert_ack_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (upAck && upReq) |=> upAck);

  // R3
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (dnReq && !dnAck) |=> dnReq);

  // R4
  assert_start_single_R4: assert property (@(posedge clk) disable iff (rst)
    strobe.start |=> !strobe.start);

  // R5
  assert_offer_after_done_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(dnReq) |-> $past(stDone));

endmodule

// File: rtl/pipe_ctrl.sv
module pipe_ctrl
  import pipe3_pkg::*;
#(
  parameter int STAGES = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       inValid,
  output logic                       inAck,
  input  logic                       outAck,
  output logic                       outValid,
  input  logic [STAGES-1:0]          stageDone,
  output logic [STAGES-1:0]          stageStart,
  output stageStrobe_t [STAGES-1:0]  strobes
);

  localparam int LINKS = STAGES + 1;

  logic [LINKS-1:0] linkReq;
  logic [LINKS-1:0] linkAck;

  assign linkReq[0]      = inValid;
  assign inAck           = linkAck[0];
  assign outValid        = linkReq[STAGES];
  assign linkAck[STAGES] = outAck;

  for (genvar i = 0; i < STAGES; i++) begin : gStage
    pipe_stage_fsm uFsm (
      .clk    (clk),
      .rst    (rst),
      .upReq  (linkReq[i]),
      .upAck  (linkAck[i]),
      .dnReq  (linkReq[i+1]),
      .dnAck  (linkAck[i+1]),
      .stDone (stageDone[i]),
      .strobe (strobes[i])
    );
    assign stageStart[i] = strobes[i].start;
  end

endmodule

// File: rtl/pipe_data.sv
module pipe_data
  import pipe3_pkg::*;
#(
  parameter int STAGES = 3,
  parameter int TAG_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  stageStrobe_t [STAGES-1:0]  strobes,
  input  logic [TAG_W-1:0]           inTag,
  output logic [STAGES*TAG_W-1:0]    stageTag,
  output logic [TAG_W-1:0]           outTag
);

  logic [TAG_W-1:0] tagQ [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : gTag
    logic [TAG_W-1:0] srcTag;
    if (i == 0) begin : gFirst
      assign srcTag = inTag;
    end else begin : gNext
      assign srcTag = tagQ[i-1];
    end

    always_ff @(posedge clk) begin
      if (rst)                  tagQ[i] <= '0;
      else if (strobes[i].latch) tagQ[i] <= srcTag;
    end

    assign stageTag[i*TAG_W +: TAG_W] = tagQ[i];
  end

  assign outTag = tagQ[STAGES-1];

endmodule

// File: rtl/pipe3_hs.sv
module pipe3_hs
  import pipe3_pkg::*;
#(
  parameter int STAGES = 3,
  parameter int TAG_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inValid,
  input  logic [TAG_W-1:0]        inTag,
  output logic                    inAck,
  output logic [STAGES-1:0]       stageStart,
  output logic [STAGES*TAG_W-1:0] stageTag,
  input  logic [STAGES-1:0]       stageDone,
  output logic                    outValid,
  output logic [TAG_W-1:0]        outTag,
  input  logic                    outAck
);

  stageStrobe_t [STAGES-1:0] strobes;

  pipe_ctrl #(.STAGES(STAGES)) uCtrl (
    .clk        (clk),
    .rst        (rst),
    .inValid    (inValid),
    .inAck      (inAck),
    .outAck     (outAck),
    .outValid   (outValid),
    .stageDone  (stageDone),
    .stageStart (stageStart),
    .strobes    (strobes)
  );

  pipe_data #(.STAGES(STAGES), .TAG_W(TAG_W)) uData (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .inTag    (inTag),
    .stageTag (stageTag),
    .outTag   (outTag)
  );

  // R3: delivered item stays offered and unchanged until taken
  assert_out_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outAck) |=> (outValid && $stable(outTag)));

endmodule

// File: tb/sim_pipe3_hs.sv
`timescale 1ns/1ps
module sim_pipe3_hs;

  localparam int STAGES = 3;
  localparam int TAG_W  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [TAG_W-1:0] inTag = '0;
  logic inAck;
  logic [STAGES-1:0] stageStart;
  logic [STAGES*TAG_W-1:0] stageTag;
  logic [STAGES-1:0] stubDone = '0;
  logic [STAGES-1:0] spurDone = '0;
  logic [STAGES-1:0] stageDone;
  logic outValid;
  logic [TAG_W-1:0] outTag;
  logic outAck = 1'b0;

  assign stageDone = stubDone | spurDone;

  pipe3_hs #(.STAGES(STAGES), .TAG_W(TAG_W)) u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inTag(inTag), .inAck(inAck),
    .stageStart(stageStart), .stageTag(stageTag), .stageDone(stageDone),
    .outValid(outValid), .outTag(outTag), .outAck(outAck)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int lat[STAGES];
  int cnt[STAGES];
  int startCount[STAGES];
  int expStart[STAGES];
  bit randLat = 0, sinkEn = 1, sinkRand = 0, overlapSeen = 0;
  int expOut = 1, rcvCount = 0, nextTag = 1, sentCount = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    for (int k = 0; k < STAGES; k++) begin
      lat[k] = 3; cnt[k] = 0; startCount[k] = 0; expStart[k] = 1;
    end
  end

  // datapath stubs
  always @(posedge clk) begin
    for (int k = 0; k < STAGES; k++) begin
      if (stageStart[k]) begin
        check(stageTag[k*TAG_W +: TAG_W] == expStart[k][TAG_W-1:0], "R4 start tag",
              int'(stageTag[k*TAG_W +: TAG_W]), expStart[k]);
        expStart[k]++;
        startCount[k]++;
        cnt[k] = randLat ? $urandom_range(1, 12) : lat[k];
        stubDone[k] <= 1'b0;
      end else if (cnt[k] > 0) begin
        cnt[k]--;
        stubDone[k] <= (cnt[k] == 0);
      end else begin
        stubDone[k] <= 1'b0;
      end
    end
    if (cnt[0] > 0 && cnt[1] > 0) overlapSeen = 1;
  end

  // sink
  always @(posedge clk) begin
    cyc++;
    if (outValid && !outAck && sinkEn && (!sinkRand || $urandom_range(0, 3) == 0)) begin
      check(outTag == expOut[TAG_W-1:0], "R7 output order", int'(outTag), expOut);
      expOut++;
      rcvCount++;
      outAck <= 1'b1;
    end else if (!outValid && outAck) begin
      outAck <= 1'b0;
    end
  end

  task automatic sendItem();
    @(negedge clk);
    inTag = nextTag[TAG_W-1:0];
    inValid = 1'b1;
    nextTag++; sentCount++;
    do @(negedge clk); while (!inAck);
    inValid = 1'b0;
    do @(negedge clk); while (inAck);
  endtask

  task automatic waitRcv(input int target);
    while (rcvCount < target) @(negedge clk);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check(inAck == 0 && outValid == 0 && stageStart == 0, "R1 in reset",
          int'({inAck, outValid, stageStart}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(inAck == 0 && outValid == 0 && stageStart == 0, "R1 after reset",
          int'({inAck, outValid, stageStart}), 0);
  endtask

  task automatic testAccept();
    int tag = nextTag;
    @(negedge clk);
    inTag = tag[TAG_W-1:0]; inValid = 1'b1;
    nextTag++; sentCount++;
    @(negedge clk);
    check(inAck == 1, "R2 ack raised", int'(inAck), 1);
    check(stageTag[TAG_W-1:0] == tag[TAG_W-1:0], "R2 tag captured", int'(stageTag[TAG_W-1:0]), tag);
    @(negedge clk);
    check(inAck == 1 && stageStart[0] == 0, "R2 ack held", int'({inAck, stageStart[0]}), 2);
    inValid = 1'b0;
    #1;
    check(stageStart[0] == 1, "R4 start pulse", int'(stageStart[0]), 1);
    @(negedge clk);
    check(stageStart[0] == 0 && inAck == 0, "R4 start single", int'({stageStart[0], inAck}), 0);
    waitRcv(sentCount);
    check(rcvCount == sentCount, "R7 single item", rcvCount, sentCount);
  endtask

  task automatic testDoneIgnored();
    int s1 = startCount[1], s2 = startCount[2], r = rcvCount;
    repeat (5) @(negedge clk);
    spurDone = '1;
    @(negedge clk);
    spurDone = '0;
    repeat (10) @(negedge clk);
    check(startCount[1] == s1 && startCount[2] == s2, "R5 stray done starts",
          startCount[1] + startCount[2], s1 + s2);
    check(outValid == 0 && rcvCount == r, "R5 stray done output", int'(outValid), 0);
    check(inAck == 0, "R5 stray done input", int'(inAck), 0);
  endtask

  task automatic testStall();
    int base = rcvCount;
    logic [TAG_W-1:0] held;
    sinkEn = 0;
    sendItem(); sendItem(); sendItem();
    while (!outValid) @(negedge clk);
    repeat (30) @(negedge clk);
    held = outTag;
    check(outTag == expOut[TAG_W-1:0], "R3 offered tag", int'(outTag), expOut);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check(outValid == 1 && outTag == held, "R3 request held", int'(outTag), int'(held));
    end
    inTag = nextTag[TAG_W-1:0]; inValid = 1'b1;
    nextTag++; sentCount++;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      check(inAck == 0, "R6 full pipeline blocks input", int'(inAck), 0);
    end
    sinkEn = 1;
    while (!inAck) @(negedge clk);
    inValid = 1'b0;
    while (inAck) @(negedge clk);
    waitRcv(base + 4);
    repeat (10) @(negedge clk);
    check(rcvCount == base + 4, "R7 stall no loss", rcvCount, base + 4);
  endtask

  task automatic testOverlap();
    int t0, t1, t2;
    for (int k = 0; k < STAGES; k++) lat[k] = 8;
    overlapSeen = 0;
    t0 = cyc;
    sendItem();
    waitRcv(sentCount);
    t1 = cyc - t0;
    repeat (5) @(negedge clk);
    t0 = cyc;
    sendItem(); sendItem();
    waitRcv(sentCount);
    t2 = cyc - t0;
    check(t2 * 4 < t1 * 7, "R8 two items overlap", t2, (t1 * 7) / 4);
    check(overlapSeen, "R8 stages busy together", int'(overlapSeen), 1);
  endtask

  task automatic testRandom();
    randLat = 1; sinkRand = 1;
    for (int i = 0; i < 20; i++) sendItem();
    waitRcv(sentCount);
    repeat (40) @(negedge clk);
    check(rcvCount == sentCount, "R7 random no loss or duplicate", rcvCount, sentCount);
    for (int k = 0; k < STAGES; k++)
      check(startCount[k] == sentCount, "R4 one start per item", startCount[k], sentCount);
    randLat = 0; sinkRand = 0;
  endtask

  initial begin
    testReset();
    testAccept();
    testDoneIgnored();
    testStall();
    testOverlap();
    testRandom();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule